// File: doc/BRIEF.md
# CAN Channel Control and Status Register

This block is the 16-bit control/status word of one CAN controller channel. The low seven bits are control flags that steer the channel: receive and transmit dominant-level select, overwrite mode, timer enable, stop, sleep and initialisation. Software never writes these flags directly. Each 16-bit write carries one set strobe and one clear strobe per flag, so a single flag can change without a read-modify-write.

The upper byte is read-only status. It is captured every clock from the channel core. It holds two-bit warning summaries of the raw 8-bit transmit and receive error counters, plus bus-off, transmit-active, receive-active and initialisation-active indications. A combinational read port returns either the full halfword or a single selected byte. Several channels reuse the block unchanged, one instance per channel address.

Top module: `can_ctl_reg`

## Requirements
- R1: After reset the full read value is 0x0101: the init flag (bit 0) is 1, the init-status bit (bit 8) is 1, and every other bit is 0.
- R2: A write with a 1 in bit 8+k and a 0 in bit k sets flag k. The flags, from k=6 down to k=0, are rx dominant level, tx dominant level, overwrite, timer, stop, sleep and init. The new value reads back from the clock edge that samples the write.
- R3: A write with a 1 in bit k and a 0 in bit 8+k clears flag k, with the same timing as R2.
- R4: A flag keeps its value when its set and clear strobes are both 1, or both 0, in a write.
- R5: A write is accepted only when wr_full_i is 1. Writes with wr_full_i low have no effect on any bit. Write data bits 15 and 7 have no effect.
- R6: Each error status field is 00 for a count below 96, 01 for a count from 96 to 127, and 11 for a count of 128 or more; the code 10 never appears. The transmit field is bits 15:14 and the receive field is bits 13:12.
- R7: Bit 11 (bus-off), bit 10 (tx active), bit 9 (rx active) and bit 8 (init active) follow their inputs one clock later. The two error fields also lag their counters by one clock.
- R8: Read bit 7 is always 0.
- R9: When rd_full_i is 0, rd_data_o[7:0] returns the high byte if rd_hi_i is 1 and the low byte if it is 0, and rd_data_o[15:8] reads 0. When rd_full_i is 1, all 16 bits are returned.
- R10: ctrl_o always equals the seven control flags, bit k holding flag k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_full_i | input | 1 | Write is a 16-bit access |
| wr_data_i | input | 16 | Set strobes [14:8], clear strobes [6:0] |
| rd_full_i | input | 1 | Read is a 16-bit access |
| rd_hi_i | input | 1 | Byte read selects the high byte |
| rd_data_o | output | 16 | Read data |
| tx_err_cnt_i | input | 8 | Raw transmit error counter |
| rx_err_cnt_i | input | 8 | Raw receive error counter |
| bus_off_i | input | 1 | Channel is bus-off |
| tx_act_i | input | 1 | Transmission in progress |
| rx_act_i | input | 1 | Reception in progress |
| init_act_i | input | 1 | Channel is in initialisation |
| ctrl_o | output | 7 | Current control flags |

## Verification
The bench drives error counts of 0, 95, 96, 127, 128 and 255. An off-by-one threshold would report the wrong field exactly at a boundary, and a careless encoder would emit the reserved code 10. It issues writes with set and clear both high for a flag, narrow writes, and writes that only toggle bits 15 and 7. A design that gives set priority, accepts byte writes or decodes the wrong bit would change a flag that must hold. Byte reads of both halves catch swapped byte lanes or stale upper bits.

// File: rtl/can_ctl_pkg.sv
package can_ctl_pkg;
  localparam int unsigned NUM_FLAGS = 7;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned SET_LSB   = 8;

  typedef enum logic [1:0] {
    LVL_OK   = 2'b00,
    LVL_WARN = 2'b01,
    LVL_RSVD = 2'b10,
    LVL_HIGH = 2'b11
  } err_lvl_e;

  typedef struct packed {
    err_lvl_e tx_lvl;
    err_lvl_e rx_lvl;
    logic     bus_off;
    logic     tx_act;
    logic     rx_act;
    logic     init_act;
  } stat_t;

  // init flag set, all others clear
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = 7'b000_0001;
endpackage

// File: rtl/can_err_lvl_enc.sv
module can_err_lvl_enc
  import can_ctl_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned WARN_LVL = 96,
  parameter int unsigned HIGH_LVL = 128
) (
  input  logic [CNT_W-1:0] cnt_i,
  output err_lvl_e         lvl_o
);
  localparam logic [CNT_W:0] WARN_C = (CNT_W+1)'(WARN_LVL);
  localparam logic [CNT_W:0] HIGH_C = (CNT_W+1)'(HIGH_LVL);

  logic [CNT_W:0] cnt_ext;
  assign cnt_ext = {1'b0, cnt_i};

  always_comb begin
    if (cnt_ext >= HIGH_C)      lvl_o = LVL_HIGH;
    else if (cnt_ext >= WARN_C) lvl_o = LVL_WARN;
    else                        lvl_o = LVL_OK;
  end
endmodule

// File: rtl/can_flag_bit.sv
module can_flag_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else if (we_i && (set_i != clr_i)) q_o <= set_i;
  end

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && set_i && !clr_i) |=> q_o);
  assert_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && clr_i && !set_i) |=> !q_o);
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (set_i == clr_i)) |=> $stable(q_o));
  assert_no_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/can_stat_cap.sv
module can_stat_cap
  import can_ctl_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned WARN_LVL = 96,
  parameter int unsigned HIGH_LVL = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             bus_off_i,
  input  logic             tx_act_i,
  input  logic             rx_act_i,
  input  logic             init_act_i,
  output stat_t            stat_o
);
  localparam stat_t STAT_RST = '{tx_lvl: LVL_OK, rx_lvl: LVL_OK, bus_off: 1'b0,
                                 tx_act: 1'b0, rx_act: 1'b0, init_act: 1'b1};

  err_lvl_e lvl [2];
  logic [CNT_W-1:0] cnt [2];
  assign cnt[0] = tx_cnt_i;
  assign cnt[1] = rx_cnt_i;

  for (genvar i = 0; i < 2; i++) begin : g_enc
    can_err_lvl_enc #(
      .CNT_W(CNT_W), .WARN_LVL(WARN_LVL), .HIGH_LVL(HIGH_LVL)
    ) u_enc (
      .cnt_i(cnt[i]),
      .lvl_o(lvl[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= STAT_RST;
    else stat_o <= '{tx_lvl: lvl[0], rx_lvl: lvl[1], bus_off: bus_off_i,
                     tx_act: tx_act_i, rx_act: rx_act_i, init_act: init_act_i};
  end

  assert_no_rsvd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o.tx_lvl != LVL_RSVD) && (stat_o.rx_lvl != LVL_RSVD));
  assert_busoff_lag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_i |=> stat_o.bus_off);
  assert_init_lag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_act_i |=> !stat_o.init_act);
endmodule

// File: rtl/can_ctl_reg.sv
module can_ctl_reg
  import can_ctl_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned WARN_LVL = 96,
  parameter int unsigned HIGH_LVL = 128
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_full_i,
  input  logic [REG_W-1:0]     wr_data_i,
  input  logic                 rd_full_i,
  input  logic                 rd_hi_i,
  output logic [REG_W-1:0]     rd_data_o,
  input  logic [CNT_W-1:0]     tx_err_cnt_i,
  input  logic [CNT_W-1:0]     rx_err_cnt_i,
  input  logic                 bus_off_i,
  input  logic                 tx_act_i,
  input  logic                 rx_act_i,
  input  logic                 init_act_i,
  output logic [NUM_FLAGS-1:0] ctrl_o
);
  localparam int unsigned BYTE_W = REG_W / 2;

  logic                 wr_ok;
  logic [NUM_FLAGS-1:0] flags;
  stat_t                stat;
  logic [REG_W-1:0]     word;

  assign wr_ok = wr_en_i && wr_full_i;

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    can_flag_bit #(.RST_VAL(FLAG_RST[k])) u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_ok),
      .set_i (wr_data_i[SET_LSB+k]),
      .clr_i (wr_data_i[k]),
      .q_o   (flags[k])
    );
  end

  can_stat_cap #(
    .CNT_W(CNT_W), .WARN_LVL(WARN_LVL), .HIGH_LVL(HIGH_LVL)
  ) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_cnt_i  (tx_err_cnt_i),
    .rx_cnt_i  (rx_err_cnt_i),
    .bus_off_i (bus_off_i),
    .tx_act_i  (tx_act_i),
    .rx_act_i  (rx_act_i),
    .init_act_i(init_act_i),
    .stat_o    (stat)
  );

  assign word   = {stat, 1'b0, flags};
  assign ctrl_o = flags;

  always_comb begin
    if (rd_full_i)    rd_data_o = word;
    else if (rd_hi_i) rd_data_o = {{BYTE_W{1'b0}}, word[REG_W-1:BYTE_W]};
    else              rd_data_o = {{BYTE_W{1'b0}}, word[BYTE_W-1:0]};
  end

  assert_narrow_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_full_i) |=> $stable(ctrl_o));
  assert_bit7_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_full_i |-> !rd_data_o[7]);
  assert_byte_upper_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_full_i |-> (rd_data_o[REG_W-1:BYTE_W] == '0));
endmodule

// File: tb/can_ctl_reg_test.sv
`timescale 1ns/1ps
module can_ctl_reg_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, wr_full = 0;
  logic [15:0] wr_data = '0;
  logic        rd_full = 1, rd_hi = 0;
  logic [15:0] rd_data;
  logic [7:0]  tx_cnt = 0, rx_cnt = 0;
  logic        bus_off = 0, tx_act = 0, rx_act = 0, init_act = 1;
  logic [6:0]  ctrl;

  int checks = 0, fails = 0;
  logic [6:0] exp_flags;

  always #10 clk = ~clk;

  can_ctl_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_full_i(wr_full),
    .wr_data_i(wr_data), .rd_full_i(rd_full), .rd_hi_i(rd_hi), .rd_data_o(rd_data),
    .tx_err_cnt_i(tx_cnt), .rx_err_cnt_i(rx_cnt), .bus_off_i(bus_off),
    .tx_act_i(tx_act), .rx_act_i(rx_act), .init_act_i(init_act), .ctrl_o(ctrl)
  );

  function automatic logic [1:0] lvl(input logic [7:0] c);
    if (c >= 8'd128)     return 2'b11;
    else if (c >= 8'd96) return 2'b01;
    else                 return 2'b00;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, sampled edge in between, check at next negedge
  task automatic do_write(input logic full, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_full = full; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_full = 0; wr_data = '0;
  endtask

  task automatic check_flags(input string req);
    rd_full = 1;
    #1;
    chk(req, {9'd0, rd_data[6:0]}, {9'd0, exp_flags});
    chk({req, " R10"}, {9'd0, ctrl}, {9'd0, exp_flags});
  endtask

  task automatic t_reset_R1;
    rd_full = 1; #1;
    chk("R1", rd_data, 16'h0101);
  endtask

  task automatic t_set_R2;
    for (int k = 1; k < 7; k++) begin
      do_write(1'b1, 16'h0100 << k);
      exp_flags[k] = 1'b1;
      check_flags("R2");
    end
  endtask

  task automatic t_clear_R3;
    do_write(1'b1, 16'h0001);
    exp_flags[0] = 1'b0;
    check_flags("R3");
    do_write(1'b1, 16'h0028);
    exp_flags[5] = 1'b0; exp_flags[3] = 1'b0;
    check_flags("R3");
  endtask

  task automatic t_both_R4;
    // bit 6 set-and-clear (currently 1), bit 0 set-and-clear (currently 0)
    do_write(1'b1, 16'h4141);
    check_flags("R4");
    // bit 5 set-and-clear (currently 0), set bit 0
    do_write(1'b1, 16'h2120);
    exp_flags[0] = 1'b1;
    check_flags("R4");
  endtask

  task automatic t_ignored_R5;
    do_write(1'b0, 16'h007F);
    check_flags("R5 narrow clear");
    do_write(1'b0, 16'h7F00);
    check_flags("R5 narrow set");
    do_write(1'b1, 16'h8080);
    check_flags("R5 bits15/7");
    rd_full = 1; #1;
    chk("R5 status untouched", {rd_data[15:8], 8'h00}, {8'h01, 8'h00});
  endtask

  task automatic t_levels_R6;
    logic [7:0] vals [6] = '{8'd0, 8'd95, 8'd96, 8'd127, 8'd128, 8'd255};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tx_cnt = vals[i]; rx_cnt = vals[5-i];
      @(negedge clk);
      rd_full = 1; #1;
      chk("R6 tx", {14'd0, rd_data[15:14]}, {14'd0, lvl(vals[i])});
      chk("R6 rx", {14'd0, rd_data[13:12]}, {14'd0, lvl(vals[5-i])});
    end
    @(negedge clk); tx_cnt = 0; rx_cnt = 0;
  endtask

  task automatic t_status_R7;
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      {bus_off, tx_act, rx_act, init_act} = 4'(p);
      #1;
      if (p > 0) chk("R7 lag", {12'd0, rd_data[11:8]}, 16'(p - 1));
      @(negedge clk);
      rd_full = 1; #1;
      chk("R7", {12'd0, rd_data[11:8]}, 16'(p));
      chk("R8", {15'd0, rd_data[7]}, 16'd0);
    end
  endtask

  task automatic t_byte_R9;
    logic [15:0] full_w;
    @(negedge clk);
    tx_cnt = 8'd100; rx_cnt = 8'd200; bus_off = 1; tx_act = 0; rx_act = 1; init_act = 0;
    @(negedge clk);
    rd_full = 1; #1; full_w = rd_data;
    chk("R9 full", full_w, {2'b01, 2'b11, 4'b1010, 1'b0, exp_flags});
    rd_full = 0; rd_hi = 1; #1;
    chk("R9 hi", rd_data, {8'h00, full_w[15:8]});
    rd_hi = 0; #1;
    chk("R9 lo", rd_data, {8'h00, full_w[7:0]});
    rd_full = 1;
  endtask

  initial begin
    exp_flags = 7'b000_0001;
    repeat (2) @(negedge clk);
    #1; t_reset_R1;
    check_flags("R1");
    rst_n = 1;
    @(negedge clk);
    t_set_R2;
    t_clear_R3;
    t_both_R4;
    t_ignored_R5;
    t_levels_R6;
    t_status_R7;
    t_byte_R9;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule